// File: doc/BRIEF.md
# Joypad Matrix Select Port

This block holds the state of eight buttons and presents them to a processor as one 8-bit port register. The processor writes two select bits. Each select bit is active low and enables one group of four buttons: one group for the directions, one for the action buttons. When both selects are low, the two groups are ORed onto the same four bits. The low nibble is inverted, so a pressed button reads as 0. A group that is not selected reads as 1s.

The button inputs are one-cycle press and release masks. The port value is recomputed only when a select write or a real change of button state takes effect. If any low-nibble bit falls from 1 to 0 at that update, the block drives a one-clock pulse on the joypad line of a five-line interrupt vector. The interrupt flag register that captures the pulse lies outside this block.

Top module: `joypad_port`

## Requirements
- R1: After an asynchronous reset, the port reads 0xFF, all eight buttons are released, and every interrupt output is 0.
- R2: Port bits 7 and 6 always read 1. A write sets the select bits (port bits 5 and 4) from `sel_wdata_i[5:4]`. Data on write bits 3:0 and 7:6 has no effect.
- R3: While port bit 4 is 0, buttons 0–3 (directions) drive nibble bits 0–3, with button n on bit n.
- R4: While port bit 5 is 0, buttons 4–7 (actions) drive nibble bits 0–3, with button n on bit n−4. When both selects are 0, the two groups are ORed bit by bit.
- R5: The nibble is inverted after the OR. A pressed, selected button reads 0. Every nibble bit with no pressed, selected button reads 1, so a port with neither group selected reads 1111 in bits 3:0.
- R6: If any nibble bit is 1 before an update and 0 after it, `irq_o[4]` is 1 for exactly the one clock that follows that edge. A nibble bit that rises does not raise the pulse.
- R7: Pressing a button that is already pressed, or releasing one that is already released, changes neither the port nor `irq_o`.
- R8: If press and release are both set for the same button in one cycle, the press wins. A select write and a button change in the same cycle take effect in a single update.
- R9: `irq_o[3:0]` are always 0.
- R10: Inputs sampled at a rising edge appear on `port_o` and `irq_o` just after that edge. Before that edge, the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| press_i | input | 8 | One-cycle mask of buttons pressed |
| release_i | input | 8 | One-cycle mask of buttons released |
| sel_we_i | input | 1 | Select register write strobe |
| sel_wdata_i | input | 8 | Write data; only bits 5:4 are used |
| port_o | output | 8 | Port register value |
| irq_o | output | 5 | Interrupt lines; bit 4 is the joypad pulse |

## Verification
A select write and a button change can take effect in the same cycle. The block must fold both into one update, so the falling-edge detector compares the old nibble with the combined new one and not with an intermediate value. The bench provokes this by writing a new select while pressing a button, and by setting press and release for one button together. It judges both the port value and whether the pulse fires against values worked out from R4, R6 and R8.

// File: rtl/joypad_pkg.sv
package joypad_pkg;
  localparam int unsigned NUM_BTN     = 8;
  localparam int unsigned GRP_W       = 4;
  localparam int unsigned NUM_GRP     = NUM_BTN / GRP_W;
  localparam int unsigned PORT_W      = 8;
  localparam int unsigned SEL_LSB     = 4;
  localparam int unsigned IRQ_LINES   = 5;
  localparam int unsigned JOY_IRQ_IDX = 4;
endpackage

// File: rtl/joypad_btn_state.sv
module joypad_btn_state #(
  parameter int unsigned NUM_BTN = joypad_pkg::NUM_BTN
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BTN-1:0] press_i,
  input  logic [NUM_BTN-1:0] release_i,
  output logic [NUM_BTN-1:0] pad_next_o,
  output logic               changed_o
);
  logic [NUM_BTN-1:0] pad_q;

  // press wins over release on the same bit
  assign pad_next_o = (pad_q & ~release_i) | press_i;
  assign changed_o  = (pad_next_o != pad_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pad_q <= '0;
    else if (changed_o) pad_q <= pad_next_o;
  end
endmodule

// File: rtl/joypad_nibble.sv
module joypad_nibble #(
  parameter int unsigned GRP_W   = joypad_pkg::GRP_W,
  parameter int unsigned NUM_GRP = joypad_pkg::NUM_GRP,
  localparam int unsigned NB     = GRP_W * NUM_GRP
) (
  input  logic [NB-1:0]      pad_i,
  input  logic [NUM_GRP-1:0] sel_n_i,
  output logic [GRP_W-1:0]   nibble_o
);
  logic [NUM_GRP-1:0][GRP_W-1:0] grp_hit;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_hit[g] = sel_n_i[g] ? '0 : pad_i[g*GRP_W +: GRP_W];
  end

  always_comb begin
    logic [GRP_W-1:0] acc;
    acc = '0;
    for (int g = 0; g < NUM_GRP; g++) acc |= grp_hit[g];
    nibble_o = ~acc;
  end
endmodule

// File: rtl/joypad_fall_det.sv
module joypad_fall_det #(
  parameter int unsigned GRP_W = joypad_pkg::GRP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             refresh_i,
  input  logic [GRP_W-1:0] old_i,
  input  logic [GRP_W-1:0] new_i,
  output logic             pulse_o
);
  logic fall;
  assign fall = refresh_i && |(old_i & ~new_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= fall;
  end
endmodule

// File: rtl/joypad_port.sv
module joypad_port #(
  parameter int unsigned NUM_BTN     = joypad_pkg::NUM_BTN,
  parameter int unsigned GRP_W       = joypad_pkg::GRP_W,
  parameter int unsigned PORT_W      = joypad_pkg::PORT_W,
  parameter int unsigned SEL_LSB     = joypad_pkg::SEL_LSB,
  parameter int unsigned IRQ_LINES   = joypad_pkg::IRQ_LINES,
  parameter int unsigned JOY_IRQ_IDX = joypad_pkg::JOY_IRQ_IDX,
  localparam int unsigned NUM_GRP    = NUM_BTN / GRP_W,
  localparam int unsigned TOP_LSB    = SEL_LSB + NUM_GRP
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BTN-1:0]   press_i,
  input  logic [NUM_BTN-1:0]   release_i,
  input  logic                 sel_we_i,
  input  logic [PORT_W-1:0]    sel_wdata_i,
  output logic [PORT_W-1:0]    port_o,
  output logic [IRQ_LINES-1:0] irq_o
);
  logic [NUM_BTN-1:0] pad_next;
  logic               pad_changed;
  logic [NUM_GRP-1:0] sel_q, sel_next;
  logic [GRP_W-1:0]   nib_q, nib_next;
  logic               refresh, joy_pulse;

  joypad_btn_state #(.NUM_BTN(NUM_BTN)) u_btn (
    .clk_i, .rst_ni, .press_i, .release_i,
    .pad_next_o(pad_next), .changed_o(pad_changed)
  );

  assign sel_next = sel_we_i ? sel_wdata_i[SEL_LSB +: NUM_GRP] : sel_q;
  assign refresh  = sel_we_i | pad_changed;

  joypad_nibble #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_nib (
    .pad_i(pad_next), .sel_n_i(sel_next), .nibble_o(nib_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '1;
      nib_q <= '1;
    end else if (refresh) begin
      sel_q <= sel_next;
      nib_q <= nib_next;
    end
  end

  joypad_fall_det #(.GRP_W(GRP_W)) u_fall (
    .clk_i, .rst_ni, .refresh_i(refresh),
    .old_i(nib_q), .new_i(nib_next), .pulse_o(joy_pulse)
  );

  always_comb begin
    port_o = '1;
    port_o[GRP_W-1:0] = nib_q;
    port_o[SEL_LSB +: NUM_GRP] = sel_q;
  end

  for (genvar i = 0; i < IRQ_LINES; i++) begin : g_irq
    if (i == JOY_IRQ_IDX) begin : g_joy
      assign irq_o[i] = joy_pulse;
    end else begin : g_idle
      assign irq_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/joypad_port_chk.sv
module joypad_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] press_i,
  input logic [7:0] release_i,
  input logic       sel_we_i,
  input logic [7:0] port_o,
  input logic [4:0] irq_o
);
  a_r2_top_bits_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_o[7:6] == 2'b11);

  a_r9_other_lines_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[3:0] == 4'b0000);

  a_r6_pulse_needs_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[4] |-> (($past(port_o[3:0]) & ~port_o[3:0]) != 4'b0000));

  a_r6_fall_gives_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(port_o[3:0]) & ~port_o[3:0]) != 4'b0000) |-> irq_o[4]);

  a_r10_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_we_i && press_i == 8'h00 && release_i == 8'h00) |=> $stable(port_o));

  a_r10_idle_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_we_i && press_i == 8'h00 && release_i == 8'h00) |=> !irq_o[4]);
endmodule

bind joypad_port joypad_port_chk u_chk (
  .clk_i, .rst_ni, .press_i, .release_i, .sel_we_i, .port_o, .irq_o
);

// File: tb/joypad_port_bench.sv
`timescale 1ns/1ps
module joypad_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] press = '0, rel = '0, wdata = '0;
  logic       we = 1'b0;
  logic [7:0] port;
  logic [4:0] irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  joypad_port u_joypad_port (
    .clk_i(clk), .rst_ni(rst_n), .press_i(press), .release_i(rel),
    .sel_we_i(we), .sel_wdata_i(wdata), .port_o(port), .irq_o(irq)
  );

  // {we, wdata, press, release, exp_port, exp_joy_irq}
  localparam logic [33:0] VEC [16] = '{
    {1'b1, 8'h20, 8'h00, 8'h00, 8'hEF, 1'b0}, // R2 R3 select directions
    {1'b0, 8'h00, 8'h01, 8'h00, 8'hEE, 1'b1}, // R3 R6 press btn0
    {1'b0, 8'h00, 8'h01, 8'h00, 8'hEE, 1'b0}, // R7 redundant press
    {1'b0, 8'h00, 8'h10, 8'h00, 8'hEE, 1'b0}, // R3 unselected action
    {1'b1, 8'h10, 8'h00, 8'h00, 8'hDE, 1'b0}, // R4 select actions
    {1'b1, 8'h00, 8'h00, 8'h00, 8'hCE, 1'b0}, // R4 both groups
    {1'b0, 8'h00, 8'h82, 8'h00, 8'hC4, 1'b1}, // R4 OR of groups
    {1'b0, 8'h00, 8'h00, 8'h01, 8'hC4, 1'b0}, // R4 bit0 held by btn4
    {1'b0, 8'h00, 8'h00, 8'h10, 8'hC5, 1'b0}, // R6 rising: no pulse
    {1'b1, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0}, // R5 none selected
    {1'b1, 8'h0F, 8'h00, 8'h00, 8'hC5, 1'b1}, // R2 ignored bits
    {1'b0, 8'h00, 8'h04, 8'h04, 8'hC1, 1'b1}, // R8 press wins
    {1'b0, 8'h00, 8'h00, 8'h08, 8'hC1, 1'b0}, // R7 redundant release
    {1'b1, 8'h20, 8'h01, 8'h00, 8'hE8, 1'b1}, // R8 write+press together
    {1'b0, 8'h00, 8'h00, 8'h07, 8'hEF, 1'b0}, // R5 release all dirs
    {1'b1, 8'h10, 8'h00, 8'h00, 8'hD7, 1'b1}  // R6 select change falls
  };

  task automatic check(string req, logic [7:0] ep, logic [4:0] ei);
    n_chk++;
    if (port !== ep || irq !== ei) begin
      n_bad++;
      $display("FAIL %s: port=%h irq=%b expected port=%h irq=%b", req, port, irq, ep, ei);
    end
  endtask

  task automatic step(logic w, logic [7:0] d, logic [7:0] p, logic [7:0] r);
    @(negedge clk);
    we = w; wdata = d; press = p; rel = r;
    @(posedge clk);
    #1;
    we = 1'b0; wdata = '0; press = '0; rel = '0;
    @(negedge clk);
  endtask

  initial begin
    #15;
    check("R1", 8'hFF, 5'b0);
    @(negedge clk) rst_n = 1'b1;
    check("R1", 8'hFF, 5'b0);
    for (int i = 0; i < 16; i++) begin
      step(VEC[i][33], VEC[i][32:25], VEC[i][24:17], VEC[i][16:9]);
      check($sformatf("R3/R4/R5/R6/R7/R8 vec%0d", i), VEC[i][8:1], {VEC[i][0], 4'b0});
    end
    // R1: reset mid-run clears buttons and selects
    rst_n = 1'b0;
    #3;
    check("R1", 8'hFF, 5'b0);
    @(negedge clk) rst_n = 1'b1;
    step(1'b1, 8'h00, 8'h00, 8'h00);
    check("R1 buttons released", 8'hCF, 5'b0);
    // R10: no change before the sampling edge
    @(negedge clk);
    press = 8'h01;
    #5;
    check("R10", 8'hCF, 5'b0);
    @(posedge clk);
    #1 press = '0;
    @(negedge clk);
    check("R10 R6", 8'hCE, 5'b10000);
    // R6: pulse lasts one clock
    @(negedge clk);
    check("R6 single cycle", 8'hCE, 5'b0);
    step(1'b0, 8'h00, 8'h00, 8'h00);
    check("R9", 8'hCE, 5'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule